// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits behind an Ethernet receiver and decides, frame by frame, whether a frame is kept or discarded. The receiver streams frame bytes together with start-of-frame and end-of-frame strobes. On the last byte it also supplies the total frame length and an error flag. The block captures the first six bytes of each frame, which form the destination address. It then judges that address against a station address and a receive mode, both of which the host programs through a byte-wide register port.

The two low bits of the mode register select how much traffic gets through. The levels are: nothing; frames for this station plus broadcast; the same plus multicast; every frame. Two further mode switches change the judgement. One shortens the station match to the first five address bytes. The other lets frames shorter than the minimum Ethernet length through instead of dropping them and marking them as runts. One clock after each end-of-frame strobe, the block issues a single-cycle decision pulse.

Top module: `rx_dest_filter`

## Requirements
- R1: The six station address bytes sit at register offsets 0x8 to 0xD and read back as written. The byte at 0x8 is compared with the first destination byte received, and 0xD with the sixth.
- R2: The mode register sits at offset 0x0 and reads back bits 7, 4, 3, 2, 1 and 0 as written. Bits 6 and 5 read as zero, and unused offsets read as zero.
- R3: With mode bits 1:0 = 00, no frame is accepted.
- R4: With mode bits 1:0 = 01, a frame is accepted when its destination equals the station address, or when all six destination bytes are 0xFF (broadcast).
- R5: With mode bits 1:0 = 10, a frame is also accepted when bit 0 of its first destination byte is 1 (multicast).
- R6: With mode bits 1:0 = 11, every frame is accepted, including frames shorter than six bytes.
- R7: With mode bit 4 set, only the first five destination bytes are compared with the station address, so the sixth byte has no effect on the station match.
- R8: A frame whose length is below 64 bytes is a runt. With mode bit 3 clear, a runt is dropped and the runt flag is raised with the decision. With bit 3 set, a runt is judged like any other frame and the runt flag stays low.
- R9: A frame that ends with the error flag high is never accepted.
- R10: The decision pulse is high for exactly one cycle, in the cycle after the end-of-frame strobe. Accept and runt are low whenever the pulse is low. A frame of fewer than six bytes has no complete address and is accepted only in mode 11.
- R11: After reset, all registers read zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at reg_addr (combinational) |
| rx_valid | input | 1 | Frame byte present on rx_byte |
| rx_sof | input | 1 | First byte of frame, qualified by rx_valid |
| rx_eof | input | 1 | Last byte of frame, qualified by rx_valid |
| rx_byte | input | 8 | Frame byte |
| rx_len | input | 16 | Frame length in bytes, valid with rx_eof |
| rx_err | input | 1 | Receiver error for the frame, valid with rx_eof |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted, with dec_valid |
| dec_runt | output | 1 | Frame dropped as runt, with dec_valid |

## Verification
Some properties hold on every cycle, and the assertions check those: the one-cycle pulse timing after end-of-frame; accept and runt never high outside the pulse; a runt flag never paired with an accept; no accept for an errored frame or while the level is "nothing". Address matching is different: whether the station, broadcast, multicast and five-byte comparisons give the right answer for given address bytes is shown only by the bench. The bench drives random and directed frames against its own model of the acceptance rules, and it also covers register readback and the under-six-byte frames.

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int MIN_LEN    = 64,
  parameter int LEN_W      = 16,
  parameter int STA_BASE   = 8,
  parameter int MODE_OFF   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [7:0]       rx_byte,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             rx_err,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic             dec_runt
);
  localparam int IDX_W = $clog2(ADDR_BYTES + 1);
  localparam logic [7:0] MODE_MASK = 8'h9F;
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(ADDR_BYTES);

  logic [7:0] sta [ADDR_BYTES];
  logic [7:0] mode_q;
  logic [7:0] dst [ADDR_BYTES];
  logic [7:0] dst_n [ADDR_BYTES];
  logic [IDX_W-1:0] idx, pos, idx_n;
  logic uc_hit, bc_hit, mc_hit, have_addr, runt, hit, fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      for (int i = 0; i < ADDR_BYTES; i++) sta[i] <= '0;
    end else if (reg_we) begin
      if (reg_addr == 4'(MODE_OFF)) mode_q <= reg_wdata & MODE_MASK;
      for (int i = 0; i < ADDR_BYTES; i++)
        if (reg_addr == 4'(STA_BASE + i)) sta[i] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = (reg_addr == 4'(MODE_OFF)) ? mode_q : 8'h00;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (reg_addr == 4'(STA_BASE + i)) reg_rdata = sta[i];
  end

  assign pos   = rx_sof ? '0 : idx;
  assign idx_n = (pos == IDX_FULL) ? pos : pos + 1'b1;

  always_comb begin
    for (int i = 0; i < ADDR_BYTES; i++)
      dst_n[i] = (rx_valid && pos == IDX_W'(i)) ? rx_byte : dst[i];
    uc_hit = 1'b1;
    bc_hit = 1'b1;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (i < ADDR_BYTES - 1 || !mode_q[4])
        uc_hit = uc_hit & (dst_n[i] == sta[i]);
      bc_hit = bc_hit & (dst_n[i] == 8'hFF);
    end
  end

  assign mc_hit    = dst_n[0][0];
  assign have_addr = (idx_n == IDX_FULL);
  assign runt      = rx_len < LEN_W'(MIN_LEN);
  assign fire      = rx_valid && rx_eof;

  always_comb begin
    case (mode_q[1:0])
      2'b00:   hit = 1'b0;
      2'b01:   hit = have_addr && (uc_hit || bc_hit);
      2'b10:   hit = have_addr && (uc_hit || bc_hit || mc_hit);
      default: hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx        <= '0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_runt   <= 1'b0;
      for (int i = 0; i < ADDR_BYTES; i++) dst[i] <= '0;
    end else begin
      if (rx_valid) begin
        idx <= idx_n;
        for (int i = 0; i < ADDR_BYTES; i++) dst[i] <= dst_n[i];
      end
      dec_valid  <= fire;
      dec_accept <= fire && hit && !rx_err && !(runt && !mode_q[3]);
      dec_runt   <= fire && runt && !mode_q[3];
    end
  end

  AST_PULSE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid == $past(rx_valid && rx_eof)); // R10
  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept && !dec_runt); // R10
  AST_RUNT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_runt |-> !dec_accept); // R8
  AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_valid && rx_eof && rx_err) |-> !dec_accept); // R9
  AST_NONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_q[1:0] == 2'b00) |-> !dec_accept); // R3
endmodule

// File: tb/rx_dest_filter_test.sv
`timescale 1ns/1ps
module rx_dest_filter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0; logic [3:0] reg_addr = 0; logic [7:0] reg_wdata = 0, reg_rdata;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0;
  logic [7:0] rx_byte = 0; logic [15:0] rx_len = 0;
  logic dec_valid, dec_accept, dec_runt;
  int n_chk = 0, n_bad = 0;
  logic [7:0] sta_m [6];
  logic [7:0] mode_m;
  logic [7:0] fb [128];

  always #2 clk = ~clk;

  rx_dest_filter uut (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .rx_valid, .rx_sof, .rx_eof, .rx_byte, .rx_len, .rx_err,
    .dec_valid, .dec_accept, .dec_runt);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
    if (a == 4'h0) mode_m = d;
    if (a >= 4'h8 && a <= 4'hD) sta_m[a-8] = d;
  endtask

  function automatic bit exp_acc(input int n, input bit err);
    bit uc = 1, bc = 1, h;
    if (err) return 0;
    if (n < 64 && !mode_m[3]) return 0;
    if (mode_m[1:0] == 2'b11) return 1;
    if (n < 6 || mode_m[1:0] == 2'b00) return 0;
    for (int i = 0; i < 6; i++) begin
      if (i < 5 || !mode_m[4]) uc &= (fb[i] == sta_m[i]);
      bc &= (fb[i] == 8'hFF);
    end
    h = uc || bc || (mode_m[1:0] == 2'b10 && fb[0][0]);
    return h;
  endfunction

  task automatic send(input int n, input bit err, input string tag);
    bit ea, er;
    ea = exp_acc(n, err);
    er = (n < 64) && !mode_m[3];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_byte = fb[i]; rx_sof = (i == 0); rx_eof = (i == n - 1);
      rx_len = 16'(n); rx_err = (i == n - 1) ? err : 1'b0;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
    check(dec_valid === 1'b1, {tag, " R10 pulse"}, dec_valid, 1);
    check(dec_accept === ea, {tag, " accept"}, dec_accept, ea);
    check(dec_runt === er, {tag, " R8 runt"}, dec_runt, er);
    @(negedge clk);
    check(dec_valid === 1'b0, "R10 single cycle", dec_valid, 0);
  endtask

  task automatic fill(input int kind);
    for (int i = 0; i < 128; i++) fb[i] = 8'($urandom);
    case (kind)
      0: for (int i = 0; i < 6; i++) fb[i] = sta_m[i];
      1: begin for (int i = 0; i < 6; i++) fb[i] = sta_m[i]; fb[5] = sta_m[5] ^ 8'h01; end
      2: for (int i = 0; i < 6; i++) fb[i] = 8'hFF;
      3: fb[0][0] = 1'b1;
      default: fb[0][0] = 1'b0;
    endcase
  endtask

  initial begin
    #800000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mode_m = 0;
    for (int i = 0; i < 6; i++) sta_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({dec_valid, dec_accept, dec_runt} === 3'b0, "R11 outputs", dec_valid, 0);
    for (int a = 0; a < 16; a++) begin
      reg_addr = 4'(a); #0.1;
      check(reg_rdata === 8'h00, "R11 regs", reg_rdata, 0);
    end
    wr(4'h0, 8'hFF);
    reg_addr = 4'h0; #0.1;
    check(reg_rdata === 8'h9F, "R2 mode readback", reg_rdata, 8'h9F);
    mode_m = 8'h9F;
    for (int i = 0; i < 6; i++) wr(4'(8 + i), 8'h10 * 8'(i) + 8'h02);
    for (int i = 0; i < 6; i++) begin
      reg_addr = 4'(8 + i); #0.1;
      check(reg_rdata === sta_m[i], "R1 station readback", reg_rdata, sta_m[i]);
    end
    reg_addr = 4'hE; #0.1;
    check(reg_rdata === 8'h00, "R2 unused offset", reg_rdata, 0);

    wr(4'h0, 8'h01); fill(0); send(64, 0, "R4 station");
    fill(1); send(64, 0, "R4 sixth byte differs");
    fill(2); send(70, 0, "R4 broadcast");
    fill(3); send(70, 0, "R4 multicast dropped");
    wr(4'h0, 8'h02); fill(3); send(70, 0, "R5 multicast");
    wr(4'h0, 8'h00); fill(0); send(64, 0, "R3 none");
    wr(4'h0, 8'h11); fill(1); send(64, 0, "R7 five-byte");
    wr(4'h0, 8'h01); fill(0); send(40, 0, "R8 runt drop");
    wr(4'h0, 8'h09); fill(0); send(40, 0, "R8 runt allowed");
    wr(4'h0, 8'h01); fill(0); send(64, 1, "R9 error");
    wr(4'h0, 8'h0B); fill(4); send(3, 0, "R6 tiny promisc");
    wr(4'h0, 8'h09); fill(2); send(4, 0, "R10 short address");
    wr(4'h0, 8'h03); fill(4); send(64, 0, "R6 promisc");

    for (int k = 0; k < 200; k++) begin
      wr(4'h0, {3'b000, 1'($urandom), 1'($urandom), 1'b0, 2'($urandom)});
      fill(int'($urandom_range(0, 4)));
      send(($urandom_range(0, 9) == 0) ? int'($urandom_range(1, 8)) : int'($urandom_range(20, 90)),
           $urandom_range(0, 7) == 0, "R3 R4 R5 R6 R7 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule